// File: doc/BRIEF.md
# Flag-conditioned relative branch unit

This block resolves a short conditional jump. A branch instruction is two bytes: an opcode byte and a signed displacement byte. From the opcode the block takes only a 4-bit condition selector. It also receives the displacement byte, the address of the instruction that follows the branch, and the five status flags. When the valid strobe is high, the block evaluates one of sixteen flag predicates. It then registers the next instruction pointer, a taken bit and a copy of the flags.

If the predicate holds, the new pointer is the following-instruction address plus the sign-extended displacement. If it does not hold, the pointer is simply the following-instruction address, which is the branch address plus two. The flags are never modified. The addition wraps at 16 bits. Displacement bytes 80h..FFh mean -128..-1, and 00h..7Fh mean 0..+127. For example, with a following address of 0056h and a displacement of FAh, the target is 0050h.

Top module: `bru_branch_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first strobe, `ip_o`, `taken_o` and `flags_o` are all zero.
- R2: The flags vector `flags_i` has bit 0 = CF, bit 1 = PF, bit 2 = ZF, bit 3 = SF and bit 4 = OF. The selectors map to conditions as follows: code 0 is taken when OF=1, code 2 when CF=1, and code 4 when ZF=1.
- R3: Code 6 (unsigned below-or-equal) is taken when CF OR ZF is 1.
- R4: Code 8 is taken when SF=1, and code A (hex) when PF=1.
- R5: Code C is taken when SF XOR OF is 1, and code E when (SF XOR OF) OR ZF is 1.
- R6: Every odd selector code is taken exactly when the even code one below it is not taken.
- R7: A strobe whose condition holds sets `taken_o` to 1 and `ip_o` to `next_ip_i` plus the sign-extended `disp_i`, on the rising clock edge that samples the strobe.
- R8: A strobe whose condition fails sets `taken_o` to 0 and `ip_o` to `next_ip_i`, on that same edge.
- R9: The target addition wraps modulo 2^16, both upward and downward.
- R10: On each strobe, `flags_o` takes the value of `flags_i`, bit for bit unchanged.
- R11: While `valid_i` is low, `ip_o`, `taken_o` and `flags_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid_i | input | 1 | Branch strobe; the inputs are sampled when it is high |
| cond_i | input | 4 | Condition selector |
| disp_i | input | 8 | Two's-complement displacement byte |
| next_ip_i | input | 16 | Address of the instruction after the branch |
| flags_i | input | 5 | Status flags {OF,SF,ZF,PF,CF} |
| ip_o | output | 16 | Registered next instruction pointer |
| taken_o | output | 1 | Registered branch-taken indication |
| flags_o | output | 5 | Registered flags, unchanged copy |

## Verification
All three results become visible on the rising edge that samples the strobe, so each result is due one clock after the inputs are applied. The bench drives the inputs on a falling edge, lets exactly one rising edge pass, and reads the outputs on the next falling edge. It then drops the strobe. After reset, the bench waits out the two-flop release before the first stimulus. The hold check reads the outputs again after several idle edges.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int IP_W   = 16;
  localparam int DISP_W = 8;
  localparam int SEL_W  = 4;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic pf;
    logic cf;
  } bru_flags_t;

  typedef enum logic [2:0] {
    PAIR_OVF  = 3'd0,
    PAIR_CRY  = 3'd1,
    PAIR_ZERO = 3'd2,
    PAIR_BE   = 3'd3,
    PAIR_SIGN = 3'd4,
    PAIR_PAR  = 3'd5,
    PAIR_LT   = 3'd6,
    PAIR_LE   = 3'd7
  } bru_pair_e;
endpackage

// File: rtl/bru_rst_sync.sv
module bru_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  bru_flags_t       flags_i,
  output logic             take_o
);
  bru_pair_e pair;
  logic      base;
  logic      lt;

  always_comb begin
    pair = bru_pair_e'(sel_i[SEL_W-1:1]);
    lt   = flags_i.sf ^ flags_i.of;
    case (pair)
      PAIR_OVF:  base = flags_i.of;
      PAIR_CRY:  base = flags_i.cf;
      PAIR_ZERO: base = flags_i.zf;
      PAIR_BE:   base = flags_i.cf | flags_i.zf;
      PAIR_SIGN: base = flags_i.sf;
      PAIR_PAR:  base = flags_i.pf;
      PAIR_LT:   base = lt;
      PAIR_LE:   base = lt | flags_i.zf;
      default:   base = 1'b0;
    endcase
    take_o = base ^ sel_i[0];
  end

  // R3
  always_comb begin
    if (sel_i == 4'h6 && (flags_i.cf === 1'b1 || flags_i.zf === 1'b1))
      be_taken_chk: assert (take_o);
  end

  // R5
  always_comb begin
    if (sel_i == 4'hF && flags_i.zf === 1'b1)
      gt_zero_chk: assert (!take_o);
  end
endmodule

// File: rtl/bru_target_add.sv
module bru_target_add #(
  parameter int IP_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [IP_W-1:0]   base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [IP_W-1:0]   target_o
);
  localparam int EXT_W = IP_W - DISP_W;

  logic [IP_W-1:0] disp_ext;

  always_comb begin
    disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    target_o = base_i + disp_ext;
  end
endmodule

// File: rtl/bru_branch_unit.sv
module bru_branch_unit
  import bru_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [SEL_W-1:0]  cond_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [IP_W-1:0]   next_ip_i,
  input  logic [4:0]        flags_i,
  output logic [IP_W-1:0]   ip_o,
  output logic              taken_o,
  output logic [4:0]        flags_o
);
  logic            rst_sync_n;
  logic            take_c;
  logic [IP_W-1:0] target_c;
  bru_flags_t      flags_in;

  logic [IP_W-1:0] ip_q, ip_n;
  logic            taken_q, taken_n;
  bru_flags_t      flags_q, flags_n;

  assign flags_in = bru_flags_t'(flags_i);

  bru_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bru_cond_eval u_cond (
    .sel_i   (cond_i),
    .flags_i (flags_in),
    .take_o  (take_c)
  );

  bru_target_add #(.IP_W(IP_W), .DISP_W(DISP_W)) u_add (
    .base_i   (next_ip_i),
    .disp_i   (disp_i),
    .target_o (target_c)
  );

  always_comb begin
    ip_n    = ip_q;
    taken_n = taken_q;
    flags_n = flags_q;
    if (valid_i) begin
      ip_n    = take_c ? target_c : next_ip_i;
      taken_n = take_c;
      flags_n = flags_in;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ip_q    <= '0;
      taken_q <= 1'b0;
      flags_q <= '0;
    end else begin
      ip_q    <= ip_n;
      taken_q <= taken_n;
      flags_q <= flags_n;
    end
  end

  assign ip_o    = ip_q;
  assign taken_o = taken_q;
  assign flags_o = flags_q;

  // R8
  not_taken_ip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && !take_c) |=> (ip_o == $past(next_ip_i) && !taken_o));

  // R7
  taken_ip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && take_c) |=>
      (taken_o && ip_o == $past(next_ip_i) + {{(IP_W-DISP_W){$past(disp_i[DISP_W-1])}}, $past(disp_i)}));

  // R10
  flags_copy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_i |=> (flags_o == $past(flags_i)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid_i |=> ($stable(ip_o) && $stable(taken_o) && $stable(flags_o)));
endmodule

// File: tb/bru_branch_unit_bench.sv
module bru_branch_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [3:0]  cond_i;
  logic [7:0]  disp_i;
  logic [15:0] next_ip_i;
  logic [4:0]  flags_i;
  logic [15:0] ip_o;
  logic        taken_o;
  logic [4:0]  flags_o;

  int n_tests;
  int n_fail;

  bru_branch_unit u_bru_branch_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cond_i(cond_i),
    .disp_i(disp_i), .next_ip_i(next_ip_i), .flags_i(flags_i),
    .ip_o(ip_o), .taken_o(taken_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // flags bit order: 0 CF, 1 PF, 2 ZF, 3 SF, 4 OF
  function automatic logic ref_take(input logic [3:0] s, input logic [4:0] f);
    logic cf, pf, zf, sf, ovf, b;
    cf = f[0]; pf = f[1]; zf = f[2]; sf = f[3]; ovf = f[4];
    case (s[3:1])
      3'd0: b = ovf;
      3'd1: b = cf;
      3'd2: b = zf;
      3'd3: b = cf | zf;
      3'd4: b = sf;
      3'd5: b = pf;
      3'd6: b = sf ^ ovf;
      default: b = (sf ^ ovf) | zf;
    endcase
    return b ^ s[0];
  endfunction

  function automatic string cond_tag(input logic [3:0] s);
    if (s[0])       return "R6";
    if (s < 4'd6)   return "R2";
    if (s < 4'd8)   return "R3";
    if (s < 4'd12)  return "R4";
    return "R5";
  endfunction

  task automatic strobe(input logic [3:0] s, input logic [7:0] d,
                        input logic [15:0] nip, input logic [4:0] f);
    @(negedge clk);
    valid_i = 1'b1; cond_i = s; disp_i = d; next_ip_i = nip; flags_i = f;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] ex_ip;
    logic        ex_t;
    rst_n = 1'b0; valid_i = 1'b0; cond_i = '0; disp_i = '0;
    next_ip_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    check("R1 ip in reset", ip_o, 16'h0);
    check("R1 taken in reset", {15'h0, taken_o}, 16'h0);
    check("R1 flags in reset", {11'h0, flags_o}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ip after release", ip_o, 16'h0);
    check("R1 flags after release", {11'h0, flags_o}, 16'h0);

    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 32; f++) begin
        logic [7:0]  d;
        logic [15:0] nip;
        d   = 8'(s * 37 + f * 11);
        nip = 16'(f * 1237 + s * 4099);
        strobe(4'(s), d, nip, 5'(f));
        ex_t  = ref_take(4'(s), 5'(f));
        ex_ip = ex_t ? nip + {{8{d[7]}}, d} : nip;
        check(cond_tag(4'(s)), {15'h0, taken_o}, {15'h0, ex_t});
        check(ex_t ? "R7 target" : "R8 sequential", ip_o, ex_ip);
        check("R10 flags", {11'h0, flags_o}, {11'h0, 5'(f)});
      end
    end

    // worked example: next 0056h, disp FAh -> 0050h (ZF=1, code 4)
    strobe(4'h4, 8'hFA, 16'h0056, 5'b00100);
    check("R7 example", ip_o, 16'h0050);
    strobe(4'h4, 8'h7F, 16'hFFFF, 5'b00100);
    check("R9 wrap up", ip_o, 16'h007E);
    strobe(4'h4, 8'h80, 16'h0000, 5'b00100);
    check("R9 wrap down", ip_o, 16'hFF80);
    strobe(4'h5, 8'h80, 16'h1234, 5'b00100);
    check("R8 not taken", ip_o, 16'h1234);
    check("R8 taken bit", {15'h0, taken_o}, 16'h0);

    // idle: new values on inputs with strobe low
    strobe(4'h2, 8'h10, 16'h2000, 5'b10001);
    @(negedge clk);
    cond_i = 4'h3; disp_i = 8'h55; next_ip_i = 16'hABCD; flags_i = 5'b01010;
    repeat (4) @(negedge clk);
    check("R11 ip hold", ip_o, 16'h2010);
    check("R11 taken hold", {15'h0, taken_o}, 16'h1);
    check("R11 flags hold", {11'h0, flags_o}, {11'h0, 5'b10001});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule